// File: doc/BRIEF.md
# Byte FIFO Pair with DMA Pacing Outputs

This block holds the two byte queues of one serial channel: a transmit queue that the CPU fills and the serializer drains, and a receive queue that the deserializer fills and the CPU drains. Each queue is 16 bytes deep. Two active-low outputs tell a DMA controller when to move data. The transmit-ready pin asks for bytes to be written. The receive-ready pin asks for bytes to be read.

The DMA mode bit picks between single-transfer pacing (mode 0) and block pacing (mode 1). In block pacing, receive-ready waits for a programmable fill threshold. Transmit-ready stays active until the queue has no free slot.

When the FIFO-enable bit is low, each queue shrinks to a one-byte holding register. Any change of that bit empties both queues. Shift logic, baud timing and interrupt encoding live elsewhere.

Top module: `uart_fifo_dma_ready`

## Requirements
- R1: While rst_n is low both ready pins are 1, both counts are 0 and rx_overrun is 0; after reset both queues are empty.
- R2: Each queue holds up to 16 bytes (count never exceeds 16) and returns bytes in the order they entered; tx_data and rx_data show the oldest stored byte.
- R3: A cpu_wr when the transmit queue is full (count equal to its capacity at that cycle) is dropped: count and stored contents do not change.
- R4: A ser_rx_push when the receive queue is full is dropped without touching stored data and sets rx_overrun to 1; rx_overrun stays 1 until a cpu_rd cycle with no new overrun, which clears it (a set in the same cycle wins).
- R5: In mode 0 (dma_mode=0), rx_rdy_n is 0 whenever the receive queue holds at least one byte and 1 when it is empty.
- R6: In mode 1, rx_rdy_n is 0 only when the receive count is at or above the trigger level; trig_sel 00, 01, 10, 11 select 1, 4, 8, 14 bytes.
- R7: In mode 0, tx_rdy_n is 0 only when the transmit queue is completely empty and goes to 1 in the cycle after the first byte is written.
- R8: In mode 1, tx_rdy_n is 0 while at least one transmit slot is free and 1 once the queue is full.
- R9: With fifo_en=0 each queue has capacity one byte, the trigger level is ignored (one byte is enough), and the ready pins follow that byte's full or empty state in both DMA modes.
- R10: A change of fifo_en empties both queues at the next clock edge, and any push, pop or write in that cycle is discarded.
- R11: A write and a pop of the transmit queue in the same cycle, with the queue neither empty nor full, leave the count unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 16-byte queues, 0: single-byte holding registers |
| dma_mode | input | 1 | 0: single-transfer pacing, 1: block pacing |
| trig_sel | input | 2 | Receive trigger level select (00=1, 01=4, 10=8, 11=14) |
| cpu_wr | input | 1 | CPU write strobe into the transmit queue |
| cpu_wdata | input | 8 | Byte written by the CPU |
| ser_tx_pop | input | 1 | Serializer takes the head transmit byte |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_count | output | 5 | Bytes stored in the transmit queue |
| ser_rx_push | input | 1 | Deserializer delivers a received byte |
| ser_rx_data | input | 8 | Received byte |
| cpu_rd | input | 1 | CPU read strobe, removes the head receive byte |
| rx_data | output | 8 | Head byte of the receive queue |
| rx_count | output | 5 | Bytes stored in the receive queue |
| rx_overrun | output | 1 | Sticky flag: a received byte was dropped |
| tx_rdy_n | output | 1 | Transmit-ready, active low |
| rx_rdy_n | output | 1 | Receive-ready, active low |

## Verification
Two pairs of events can land in the same cycle. The first is a CPU write together with a serializer pop on a partly filled transmit queue. The second is a push into a full receive queue together with a CPU read, where the overrun set and the overrun clear compete. The bench drives each pair in a single cycle. It judges the result by the count after the edge, by the head byte that follows, and by rx_overrun staying 1. Draining the queue afterwards confirms that the dropped byte never entered storage and that the order was kept.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  // Trigger threshold in bytes for a select code; one byte when queues are off.
  function automatic int trig_bytes(input logic [1:0] sel, input logic en, input int depth);
    int lvl;
    if (!en) begin
      lvl = 1;
    end else begin
      case (sel)
        2'b00:   lvl = 1;
        2'b01:   lvl = depth / 4;
        2'b10:   lvl = depth / 2;
        default: lvl = depth - 2;
      endcase
    end
    return lvl;
  endfunction

  // Capacity of a queue for the current enable state.
  function automatic int queue_cap(input logic en, input int depth);
    return en ? depth : 1;
  endfunction

  // Next value of a circular pointer.
  function automatic int ptr_next(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
  import uart_dma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          push_drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok, pop_ok;

  assign full      = (count >= cap);
  assign empty     = (count == '0);
  assign push_ok   = push && !full && !flush;
  assign push_drop = push && full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ptr_next(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ready_encoder.sv
module ready_encoder #(
  parameter bit  IS_RX = 1'b0,
  parameter int  DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          rst_n,
  input  logic          dma_mode,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] trig,
  output logic          rdy_n
);

  logic active;

  generate
    if (IS_RX) begin : g_rx
      logic unused_cap;
      assign unused_cap = ^cap;
      // mode 1 waits for the threshold, mode 0 wants any byte
      assign active = dma_mode ? (count >= trig) : (count != '0);
    end else begin : g_tx
      logic unused_trig;
      assign unused_trig = ^trig;
      // mode 1 wants any free slot, mode 0 wants a fully empty queue
      assign active = dma_mode ? (count < cap) : (count == '0);
    end
  endgenerate

  assign rdy_n = !(rst_n && active);

endmodule

// File: rtl/uart_fifo_dma_ready.sv
module uart_fifo_dma_ready
  import uart_dma_pkg::*;
#(
  parameter int  DEPTH = 16,
  parameter int  DW    = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [1:0]    trig_sel,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] tx_data,
  output logic [CW-1:0] tx_count,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  input  logic          cpu_rd,
  output logic [DW-1:0] rx_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_overrun,
  output logic          tx_rdy_n,
  output logic          rx_rdy_n
);

  logic          en_q;
  logic          flush;
  logic [CW-1:0] cap;
  logic [CW-1:0] trig;
  logic          tx_wr_drop;
  logic          rx_overrun_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush = (fifo_en != en_q);
  assign cap   = CW'(queue_cap(fifo_en, DEPTH));
  assign trig  = CW'(trig_bytes(trig_sel, fifo_en, DEPTH));

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cap       (cap),
    .push      (cpu_wr),
    .push_data (cpu_wdata),
    .pop       (ser_tx_pop),
    .head      (tx_data),
    .count     (tx_count),
    .push_drop (tx_wr_drop)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cap       (cap),
    .push      (ser_rx_push),
    .push_data (ser_rx_data),
    .pop       (cpu_rd),
    .head      (rx_data),
    .count     (rx_count),
    .push_drop (rx_overrun_evt)
  );

  // sticky overrun: a new drop wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rx_overrun <= 1'b0;
    else if (rx_overrun_evt) rx_overrun <= 1'b1;
    else if (cpu_rd)         rx_overrun <= 1'b0;
  end

  ready_encoder #(.IS_RX(1'b0), .DEPTH(DEPTH)) u_tx_rdy (
    .rst_n    (rst_n),
    .dma_mode (dma_mode),
    .count    (tx_count),
    .cap      (cap),
    .trig     (trig),
    .rdy_n    (tx_rdy_n)
  );

  ready_encoder #(.IS_RX(1'b1), .DEPTH(DEPTH)) u_rx_rdy (
    .rst_n    (rst_n),
    .dma_mode (dma_mode),
    .count    (rx_count),
    .cap      (cap),
    .trig     (trig),
    .rdy_n    (rx_rdy_n)
  );

endmodule

// File: rtl/uart_fifo_dma_ready_chk.sv
module uart_fifo_dma_ready_chk #(
  parameter int  DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_mode,
  input logic          cpu_wr,
  input logic          ser_tx_pop,
  input logic          ser_rx_push,
  input logic          flush,
  input logic [CW-1:0] cap,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rx_overrun,
  input logic          tx_wr_drop,
  input logic          tx_rdy_n,
  input logic          rx_rdy_n
);

  logic [CW-1:0] cap_m1;
  assign cap_m1 = cap - CW'(1);

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> (tx_rdy_n && rx_rdy_n));

  p_depth_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  p_tx_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_drop && !ser_tx_pop) |=> $stable(tx_count));

  p_rx_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == cap && ser_rx_push && !flush) |=> rx_overrun);

  p_rx_mode0_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && rx_count == '0 && ser_rx_push && !flush) |=> (dma_mode || !rx_rdy_n));

  p_tx_mode0_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && tx_count == CW'(1) && ser_tx_pop && !cpu_wr && !flush) |=> (dma_mode || !tx_rdy_n));

  p_tx_last_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == cap_m1 && cpu_wr && !ser_tx_pop && !flush) |=> tx_rdy_n);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_count == '0 && rx_count == '0));

endmodule

bind uart_fifo_dma_ready uart_fifo_dma_ready_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dma_mode    (dma_mode),
  .cpu_wr      (cpu_wr),
  .ser_tx_pop  (ser_tx_pop),
  .ser_rx_push (ser_rx_push),
  .flush       (flush),
  .cap         (cap),
  .tx_count    (tx_count),
  .rx_count    (rx_count),
  .rx_overrun  (rx_overrun),
  .tx_wr_drop  (tx_wr_drop),
  .tx_rdy_n    (tx_rdy_n),
  .rx_rdy_n    (rx_rdy_n)
);

// File: tb/tb_uart_fifo_dma_ready.sv
`timescale 1ns/1ps
module tb_uart_fifo_dma_ready;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic       dma_mode = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic       ser_tx_pop = 1'b0;
  logic [7:0] tx_data;
  logic [4:0] tx_count;
  logic       ser_rx_push = 1'b0;
  logic [7:0] ser_rx_data = 8'h00;
  logic       cpu_rd = 1'b0;
  logic [7:0] rx_data;
  logic [4:0] rx_count;
  logic       rx_overrun;
  logic       tx_rdy_n;
  logic       rx_rdy_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_dma_ready dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .trig_sel(trig_sel), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .ser_tx_pop(ser_tx_pop), .tx_data(tx_data), .tx_count(tx_count),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .cpu_rd(cpu_rd),
    .rx_data(rx_data), .rx_count(rx_count), .rx_overrun(rx_overrun),
    .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_tx(input logic [7:0] b);
    cpu_wr = 1'b1; cpu_wdata = b; tick(); cpu_wr = 1'b0;
  endtask

  task automatic pop_tx();
    ser_tx_pop = 1'b1; tick(); ser_tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    ser_rx_push = 1'b1; ser_rx_data = b; tick(); ser_rx_push = 1'b0;
  endtask

  task automatic rd_rx();
    cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_rdy_n in reset", tx_rdy_n, 1);
    chk("R1 rx_rdy_n in reset", rx_rdy_n, 1);
    chk("R1 tx_count in reset", tx_count, 0);
    chk("R1 rx_count in reset", rx_count, 0);
    chk("R1 overrun in reset", rx_overrun, 0);
    @(negedge clk); rst_n = 1'b1; tick(); tick();
    chk("R1 tx_rdy_n after reset", tx_rdy_n, 0);
    chk("R1 rx_rdy_n after reset", rx_rdy_n, 1);
  endtask

  task automatic t_tx_mode0();
    dma_mode = 1'b0;
    wr_tx(8'hA0);
    chk("R7 tx_rdy_n after first write", tx_rdy_n, 1);
    wr_tx(8'hA1); wr_tx(8'hA2);
    chk("R7 tx_rdy_n partly filled", tx_rdy_n, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R2 tx order mode0", tx_data, 8'hA0 + i);
      pop_tx();
    end
    chk("R7 tx_rdy_n after drain", tx_rdy_n, 0);
    chk("R7 tx_count after drain", tx_count, 0);
  endtask

  task automatic t_tx_mode1();
    dma_mode = 1'b1;
    for (int i = 0; i < 15; i++) wr_tx(8'h10 + i);
    chk("R8 tx_rdy_n one slot free", tx_rdy_n, 0);
    wr_tx(8'h1F);
    chk("R8 tx_rdy_n full", tx_rdy_n, 1);
    chk("R2 tx_count full", tx_count, 16);
    wr_tx(8'hEE);
    chk("R3 tx_count after write to full", tx_count, 16);
    chk("R2 tx head when full", tx_data, 8'h10);
    pop_tx();
    chk("R8 tx_rdy_n after one pop", tx_rdy_n, 0);
    for (int i = 1; i < 16; i++) begin
      chk("R3 tx order, dropped byte absent", tx_data, 8'h10 + i);
      pop_tx();
    end
    chk("R3 tx_count after drain", tx_count, 0);
  endtask

  task automatic t_rx_mode0();
    dma_mode = 1'b0;
    chk("R5 rx_rdy_n empty", rx_rdy_n, 1);
    push_rx(8'h5A);
    chk("R5 rx_rdy_n one byte", rx_rdy_n, 0);
    chk("R2 rx head", rx_data, 8'h5A);
    rd_rx();
    chk("R5 rx_rdy_n after read", rx_rdy_n, 1);
  endtask

  task automatic t_rx_mode1();
    int lvl [4] = '{1, 4, 8, 14};
    dma_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      tick();
      for (int i = 0; i < lvl[s] - 1; i++) push_rx(8'(i));
      chk($sformatf("R6 rx_rdy_n below trigger sel=%0d", s), rx_rdy_n, 1);
      push_rx(8'hC0);
      chk($sformatf("R6 rx_rdy_n at trigger sel=%0d", s), rx_rdy_n, 0);
      rd_rx();
      chk($sformatf("R6 rx_rdy_n after read sel=%0d", s), rx_rdy_n, 1);
      for (int i = 0; i < lvl[s] - 1; i++) rd_rx();
      chk($sformatf("R6 rx_count drained sel=%0d", s), rx_count, 0);
    end
  endtask

  task automatic t_overrun();
    dma_mode = 1'b1; trig_sel = 2'b00;
    for (int i = 0; i < 16; i++) push_rx(8'h40 + i);
    chk("R4 overrun before drop", rx_overrun, 0);
    push_rx(8'hAA);
    chk("R4 overrun set", rx_overrun, 1);
    chk("R4 rx_count held", rx_count, 16);
    chk("R4 rx head kept", rx_data, 8'h40);
    rd_rx();
    chk("R4 overrun cleared by read", rx_overrun, 0);
    for (int i = 1; i < 16; i++) begin
      chk("R4 rx order, dropped byte absent", rx_data, 8'h40 + i);
      rd_rx();
    end
    chk("R4 rx_count after drain", rx_count, 0);
  endtask

  task automatic t_single();
    fifo_en = 1'b0; tick();
    dma_mode = 1'b1; trig_sel = 2'b11; tick();
    chk("R9 tx_rdy_n empty holding reg", tx_rdy_n, 0);
    wr_tx(8'h55);
    chk("R9 tx_rdy_n holding reg full", tx_rdy_n, 1);
    wr_tx(8'h66);
    chk("R9 tx_count capped at one", tx_count, 1);
    chk("R9 tx head kept", tx_data, 8'h55);
    pop_tx();
    chk("R9 tx_rdy_n after pop", tx_rdy_n, 0);
    push_rx(8'h77);
    chk("R9 rx_rdy_n ignores trigger", rx_rdy_n, 0);
    push_rx(8'h88);
    chk("R9 rx overrun at one byte", rx_overrun, 1);
    chk("R9 rx head kept", rx_data, 8'h77);
    rd_rx();
    chk("R9 rx_count after read", rx_count, 0);
    fifo_en = 1'b1; tick();
  endtask

  task automatic t_flush();
    dma_mode = 1'b0;
    for (int i = 0; i < 3; i++) begin wr_tx(8'h20 + i); push_rx(8'h60 + i); end
    chk("R10 tx_count before flush", tx_count, 3);
    chk("R10 rx_count before flush", rx_count, 3);
    fifo_en = 1'b0; cpu_wr = 1'b1; cpu_wdata = 8'h99; tick(); cpu_wr = 1'b0;
    chk("R10 tx_count flushed, write dropped", tx_count, 0);
    chk("R10 rx_count flushed", rx_count, 0);
    chk("R10 rx_rdy_n after flush", rx_rdy_n, 1);
    chk("R10 tx_rdy_n after flush", tx_rdy_n, 0);
    fifo_en = 1'b1; tick();
  endtask

  task automatic t_same_cycle();
    dma_mode = 1'b0;
    wr_tx(8'hB1); wr_tx(8'hB2);
    cpu_wr = 1'b1; cpu_wdata = 8'hB3; ser_tx_pop = 1'b1; tick();
    cpu_wr = 1'b0; ser_tx_pop = 1'b0;
    chk("R11 tx_count write+pop", tx_count, 2);
    chk("R11 tx head advanced", tx_data, 8'hB2);
    pop_tx();
    chk("R11 tx new byte kept", tx_data, 8'hB3);
    pop_tx();
    for (int i = 0; i < 16; i++) push_rx(8'h30 + i);
    ser_rx_push = 1'b1; ser_rx_data = 8'hFF; cpu_rd = 1'b1; tick();
    ser_rx_push = 1'b0; cpu_rd = 1'b0;
    chk("R4 rx_count push-on-full with read", rx_count, 15);
    chk("R4 overrun set wins over read", rx_overrun, 1);
    chk("R4 rx head after read", rx_data, 8'h31);
    for (int i = 1; i < 16; i++) begin
      chk("R2 rx order after same-cycle drop", rx_data, 8'h30 + i);
      rd_rx();
    end
    chk("R4 overrun cleared", rx_overrun, 0);
    chk("R2 rx_count drained", rx_count, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_tx_mode0();
    t_tx_mode1();
    t_rx_mode0();
    t_rx_mode1();
    t_overrun();
    t_single();
    t_flush();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule